// File: doc/BRIEF.md
# Five-Stage Nonlinear Feedback Sequence Generator

This block is an autonomous binary sequence source built from a five-stage shift register. Each enabled clock moves every stage one place toward the output. The freshly computed feedback bit enters the newest stage. The feedback is a small AND/XOR function of the three oldest stages. From the default start state it produces a 21-bit pattern that repeats without end. The next state depends only on the present state and never on a data input.

A synchronous load writes a 5-bit start state and takes priority over shifting. A build-time mode selects between two feedback variants:
- The minimal variant keeps three parasitic short cycles.
- The completed variant forces every start state into the 21-state main cycle.

The completed variant lets a register that starts from any value, including all zeros, fall into the wanted pattern on its own.

Top module: `nlfsr_gen`

## Requirements
- R1: A synchronous active-high reset sets `state_out` to the default start value 5'b01100. Bit i of `state_out` holds sequence bit b(n+i), and `bit_out` equals `state_out[0]`, the oldest stage.
- R2: When `load` is high at a clock edge, `state_out` takes the value of `seed` at that edge, whether `en` is high or low.
- R3: When `load` and `en` are both low, `state_out` keeps its value.
- R4: On an enabled shift without load, the new `state_out[3:0]` equals the old `state_out[4:1]`.
- R5: Starting from the reset value with `en` held high, `bit_out` gives 001100111010110111110 (leftmost first), repeating with period 21, in both modes.
- R6: In minimal mode the all-zero state maps to itself (period 1).
- R7: In minimal mode the loaded state 5'b00001 yields the period-5 stream 1,0,0,0,0. The loaded state 5'b01010 yields the period-5 stream 0,1,0,1,0.
- R8: In completed mode every one of the 32 start states reaches a window of the period-21 sequence within 16 enabled shifts, and it stays in that cycle afterwards.
- R9: In completed mode the feedback is 1 for any state outside the main cycle, so the all-zero state moves to 5'b10000 after one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the default start value |
| en | input | 1 | Shift enable |
| load | input | 1 | Synchronous start-state load, priority over shifting |
| seed | input | 5 | Start state written by `load` (bit i = b(n+i)) |
| bit_out | output | 1 | Serial sequence output (oldest stage) |
| state_out | output | 5 | Present register contents |

## Verification
Every result comes straight from the single state register. A load, a hold or a shift is therefore visible on `state_out` and `bit_out` one clock edge after the inputs that caused it. The bench changes its inputs and samples the outputs 1 ns after each rising edge. Each sample therefore reflects exactly the edges counted so far.

For the stream checks, sample k is compared with b(k) after k enabled edges. The completed-mode sweep loads each of the 32 states and applies 16 shifts. It then tests membership in the 21 windows, which the bench derives from the expected pattern.

// File: rtl/nlfsr_pkg.sv
package nlfsr_pkg;

  localparam int unsigned STAGES   = 5;
  localparam int unsigned N_STATES = 1 << STAGES;

  typedef enum logic {
    FB_MINIMAL  = 1'b0,
    FB_COMPLETE = 1'b1
  } fb_mode_e;

  // Base recurrence: newest bit = oldest XOR (second AND third).
  function automatic logic base_fb(input logic [STAGES-1:0] s);
    return s[0] ^ (s[1] & s[2]);
  endfunction

  // Marks every state visited in len steps of the base recurrence from start.
  function automatic logic [N_STATES-1:0] cycle_mask(input logic [STAGES-1:0] start,
                                                     input int unsigned len);
    logic [N_STATES-1:0] m;
    logic [STAGES-1:0]   s;
    m = '0;
    s = start;
    for (int unsigned i = 0; i < len; i++) begin
      m[s] = 1'b1;
      s    = {base_fb(s), s[STAGES-1:1]};
    end
    return m;
  endfunction

endpackage

// File: rtl/nlfsr_fb.sv
module nlfsr_fb
  import nlfsr_pkg::*;
#(
  parameter fb_mode_e              MODE   = FB_COMPLETE,
  parameter logic [STAGES-1:0]     START  = 5'b01100,
  parameter int unsigned           PERIOD = 21
) (
  input  logic [STAGES-1:0] st,
  output logic              fb
);

  localparam logic [N_STATES-1:0] ON_CYCLE = cycle_mask(START, PERIOD);

  generate
    if (MODE == FB_COMPLETE) begin : g_complete
      // Off-cycle states are steered with a constant 1.
      always_comb fb = ON_CYCLE[st] ? base_fb(st) : 1'b1;
    end else begin : g_minimal
      always_comb fb = base_fb(st);
    end
  endgenerate

endmodule

// File: rtl/nlfsr_reg.sv
module nlfsr_reg
  import nlfsr_pkg::*;
#(
  parameter logic [STAGES-1:0] START = 5'b01100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [STAGES-1:0] seed,
  input  logic              fb,
  output logic [STAGES-1:0] st
);

  always_ff @(posedge clk) begin
    if (rst)       st <= START;
    else if (load) st <= seed;
    else if (en)   st <= {fb, st[STAGES-1:1]};
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> st == START);

  assert_load_priority_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> st == $past(seed));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && !$past(en)) |-> $stable(st));

  assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && $past(en)) |-> st[STAGES-2:0] == $past(st[STAGES-1:1]));

endmodule

// File: rtl/nlfsr_gen.sv
module nlfsr_gen
  import nlfsr_pkg::*;
#(
  parameter fb_mode_e          MODE   = FB_COMPLETE,
  parameter logic [STAGES-1:0] START  = 5'b01100,
  parameter int unsigned       PERIOD = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [STAGES-1:0] seed,
  output logic              bit_out,
  output logic [STAGES-1:0] state_out
);

  localparam logic [N_STATES-1:0] ON_CYCLE = cycle_mask(START, PERIOD);

  logic              fb;
  logic [STAGES-1:0] st;

  nlfsr_fb #(.MODE(MODE), .START(START), .PERIOD(PERIOD)) u_fb (
    .st (st),
    .fb (fb)
  );

  nlfsr_reg #(.START(START)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .load (load),
    .seed (seed),
    .fb   (fb),
    .st   (st)
  );

  assign bit_out   = st[0];
  assign state_out = st;

  // Once inside the main cycle, an enabled shift never leaves it.
  assert_cycle_closed_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && $past(en) && ON_CYCLE[$past(st)]) |-> ON_CYCLE[st]);

  generate
    if (MODE == FB_COMPLETE) begin : g_chk_complete
      assert_zero_escapes_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(en) && $past(st) == '0) |-> st[STAGES-1]);
    end else begin : g_chk_minimal
      assert_zero_sticks_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(en) && $past(st) == '0) |-> st == '0);
    end
  endgenerate

endmodule

// File: tb/sim_nlfsr_gen.sv
`timescale 1ns/1ps
module sim_nlfsr_gen;
  import nlfsr_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [4:0] seed = '0;
  logic bo0, bo1;
  logic [4:0] so0, so1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [0:20] SEQ = 21'b001100111010110111110;

  always #4 clk = ~clk;

  nlfsr_gen #(.MODE(FB_MINIMAL)) u0 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .bit_out(bo0), .state_out(so0));

  nlfsr_gen #(.MODE(FB_COMPLETE)) u1 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .bit_out(bo1), .state_out(so1));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_main(input logic [4:0] s);
    for (int k = 0; k < 21; k++) begin
      logic [4:0] w;
      for (int i = 0; i < 5; i++) w[i] = SEQ[(k + i) % 21];
      if (w == s) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic do_load(input logic [4:0] v, input logic e);
    load = 1'b1; seed = v; en = e;
    tick();
    load = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] snap;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset value
    chk(so0 == 5'b01100, "R1 u0 reset", so0, 5'b01100);
    chk(so1 == 5'b01100, "R1 u1 reset", so1, 5'b01100);
    chk(bo1 == so1[0], "R1 bit_out oldest", bo1, so1[0]);

    // R5 main stream, both modes
    en = 1'b1;
    for (int k = 0; k < 42; k++) begin
      chk(bo0 == SEQ[k % 21], "R5 u0 stream", bo0, SEQ[k % 21]);
      chk(bo1 == SEQ[k % 21], "R5 u1 stream", bo1, SEQ[k % 21]);
      tick();
    end

    // R3 hold
    do_load(5'b10110, 1'b0);
    en = 1'b0;
    snap = so0;
    repeat (3) tick();
    chk(so0 == snap, "R3 u0 hold", so0, snap);
    chk(so1 == snap, "R3 u1 hold", so1, snap);

    // R2, R4, R8 sweep over all start states
    for (int s = 0; s < 32; s++) begin
      do_load(s[4:0], 1'b1);
      chk(so0 == s[4:0], "R2 u0 load over enable", so0, s);
      chk(so1 == s[4:0], "R2 u1 load over enable", so1, s);
      en = 1'b1;
      tick();
      chk(so0[3:0] == s[4:1], "R4 u0 shift", so0[3:0], s[4:1]);
      chk(so1[3:0] == s[4:1], "R4 u1 shift", so1[3:0], s[4:1]);
      repeat (15) tick();
      chk(in_main(so1), "R8 u1 reaches main cycle", so1, s);
      tick();
      chk(in_main(so1), "R8 u1 stays in main cycle", so1, s);
    end

    // R6 / R9 zero state
    do_load(5'b00000, 1'b0);
    en = 1'b1;
    tick();
    chk(so1 == 5'b10000, "R9 u1 zero escapes", so1, 5'b10000);
    chk(so0 == 5'b00000, "R6 u0 zero stays", so0, 0);
    repeat (4) tick();
    chk(so0 == 5'b00000, "R6 u0 zero period 1", so0, 0);

    // R7 short cycles in minimal mode
    do_load(5'b00001, 1'b0);
    en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      chk(bo0 == (k % 5 == 0), "R7 u0 10000 stream", bo0, (k % 5 == 0));
      tick();
    end
    chk(so0 == 5'b00001, "R7 u0 10000 period 5", so0, 5'b00001);

    do_load(5'b01010, 1'b0);
    en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      chk(bo0 == ((k % 5) % 2 == 1), "R7 u0 01010 stream", bo0, ((k % 5) % 2 == 1));
      tick();
    end
    chk(so0 == 5'b01010, "R7 u0 01010 period 5", so0, 5'b01010);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule